// File: doc/BRIEF.md
# Narrow-Access Register Lane Adapter

This block sits in front of the register file of an SD host controller. The register file stores only 32-bit words in big-endian byte order. The requester works at the usual little-endian register offsets and issues byte, halfword or word accesses. The adapter turns each request into whole-word operations on the register file.

For a narrow read, the adapter flips the low address bits so that the big-endian word returns the lane the requester expects. For a narrow write, it reads the aligned word, replaces one lane and writes the word back. A halfword write to the transfer-mode register is not sent on; the adapter keeps it in a shadow register. It is written out together with the next halfword command write as a single word, so the two fields land in the same cycle. Reserved bits in the block-size and host-control registers are cleared on their way in.

Upstream, the requester sees a request channel and a response channel, each with valid/ready. Only one access is in flight at a time. `req_ready` is high only while the adapter is idle, so a request waits until the previous response has been taken. A response stays on `rsp_valid` with stable data for as long as `rsp_ready` is low. Downstream there is a word port with a fixed read latency of one cycle.

Top module: `sdreg_lane_adapter`

## Requirements
- R1: A word access (`req_size` = 2) reads or writes the word at `req_addr` with the two low address bits forced to zero. There is no lane remapping.
- R2: A halfword read (`req_size` = 1) at address A returns bits [16*A[1]+15 : 16*A[1]] of word A&~3, zero-extended. The one exception is address 0xFE (host version), which returns bits [15:0] of word 0xFC.
- R3: A byte read (`req_size` = 0) at address A returns bits [8*A[1:0]+7 : 8*A[1:0]] of word A&~3, zero-extended.
- R4: A halfword write to 0x0C (transfer mode) makes no downstream access. It only updates the shadow value.
- R5: A halfword write to 0x0E (command) makes exactly one downstream access. It is a write to word 0x0C with the command value in bits 31:16 and the shadow value in bits 15:0.
- R6: Any other byte or halfword write is a downstream read of the aligned word followed by a write to the same word. The write changes only the halfword lane at bit 16*A[1] or the byte lane at bit 8*A[1:0].
- R7: Before a halfword write to 0x04 (block size) is stored, bits 14:12 of its value are cleared. A halfword write to 0x06 is stored unmasked.
- R8: Before a byte write to 0x28 (host control) is stored, bits 0 and 2 of its value are cleared. A byte write to 0x29 is stored unmasked.
- R9: Only one access is in flight. `req_ready` is low from the cycle after a request is accepted until its response has been taken.
- R10: While `rsp_valid` is high and `rsp_ready` is low, the response and its data are held stable. Write responses carry data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Adapter can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | ADDR_W | Little-endian byte offset |
| req_wdata | input | 32 | Write value, right-aligned for narrow writes |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_rdata | output | 32 | Read value, zero-extended; 0 for writes |
| mem_en | output | 1 | Word port strobe |
| mem_we | output | 1 | Word port write |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_wdata | output | 32 | Word write data |
| mem_rdata | input | 32 | Word read data, valid one cycle after a read strobe |

## Verification
Reads go to one known word at every byte and halfword offset. Each lane then returns a different value, so a swapped or unswizzled lane shows up at once. The host-version address is read next to its word neighbour, which separates the exception from the general rule. Writes are tried in three ways: a plain narrow write onto a patterned word, which shows a lane replacement that leaks into other lanes; the same write at the masked registers and at their neighbours, which shows the reserved-bit clearing is tied to the exact address; and a transfer-mode/command pair, with downstream reads and writes counted, which shows the deferral and the merge.

// File: rtl/sdreg_pkg.sv
package sdreg_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_READ  = 3'd1,
    ST_MERGE = 3'd2,
    ST_WRITE = 3'd3,
    ST_RESP  = 3'd4
  } adp_state_e;

  localparam int unsigned OFS_BLKSZ = 'h04;
  localparam int unsigned OFS_XFER  = 'h0C;
  localparam int unsigned OFS_CMD   = 'h0E;
  localparam int unsigned OFS_HCTL  = 'h28;
  localparam int unsigned OFS_HVER  = 'hFE;

  localparam logic [31:0] BLKSZ_CLR = 32'h0000_7000;
  localparam logic [31:0] HCTL_CLR  = 32'h0000_0005;

endpackage

// File: rtl/sdreg_addr_swz.sv
module sdreg_addr_swz
  import sdreg_pkg::*;
#(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned BLK_OFS  = OFS_BLKSZ,
  parameter int unsigned XFER_OFS = OFS_XFER,
  parameter int unsigned CMD_OFS  = OFS_CMD,
  parameter int unsigned HCTL_OFS = OFS_HCTL,
  parameter int unsigned HVER_OFS = OFS_HVER
) (
  input  logic              is_write,
  input  logic [1:0]        size,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] word_addr,
  output logic [4:0]        lane_shift,
  output logic [31:0]       clr_mask,
  output logic              hit_xfer,
  output logic              hit_cmd
);

  localparam logic [ADDR_W-1:0] A_BLK  = ADDR_W'(BLK_OFS);
  localparam logic [ADDR_W-1:0] A_XFER = ADDR_W'(XFER_OFS);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(CMD_OFS);
  localparam logic [ADDR_W-1:0] A_HCTL = ADDR_W'(HCTL_OFS);
  localparam logic [ADDR_W-1:0] A_HVER = ADDR_W'(HVER_OFS);

  logic [ADDR_W-1:0] phys;

  // Read path: swizzle the offset, then pick the big-endian lane.
  always_comb begin
    phys = addr;
    if (!is_write) begin
      if (size == SZ_HALF && addr != A_HVER) phys = addr ^ ADDR_W'(2);
      else if (size == SZ_BYTE)              phys = addr ^ ADDR_W'(3);
    end
  end

  assign word_addr = {phys[ADDR_W-1:2], 2'b00};

  always_comb begin
    lane_shift = 5'd0;
    if (is_write) begin
      // Write path: lane taken straight from the logical offset.
      if (size == SZ_HALF)      lane_shift = {addr[1], 4'b0000};
      else if (size == SZ_BYTE) lane_shift = {addr[1:0], 3'b000};
    end else begin
      // Big-endian: offset 0 in the word is the most significant lane.
      if (size == SZ_HALF)      lane_shift = {~phys[1], 4'b0000};
      else if (size == SZ_BYTE) lane_shift = {~phys[1:0], 3'b000};
    end
  end

  always_comb begin
    clr_mask = '0;
    if (is_write && size == SZ_HALF && addr == A_BLK)  clr_mask = BLKSZ_CLR;
    if (is_write && size == SZ_BYTE && addr == A_HCTL) clr_mask = HCTL_CLR;
  end

  assign hit_xfer = is_write && (size == SZ_HALF) && (addr == A_XFER);
  assign hit_cmd  = is_write && (size == SZ_HALF) && (addr == A_CMD);

endmodule

// File: rtl/sdreg_lane_unit.sv
module sdreg_lane_unit
  import sdreg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [1:0]        size,
  input  logic [4:0]        shift,
  input  logic [DATA_W-1:0] old_word,
  input  logic [DATA_W-1:0] new_val,
  output logic [DATA_W-1:0] merged,
  output logic [DATA_W-1:0] extract
);

  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] lane_pos;

  always_comb begin
    case (size)
      SZ_BYTE: lane_mask = DATA_W'(32'h0000_00FF);
      SZ_HALF: lane_mask = DATA_W'(32'h0000_FFFF);
      default: lane_mask = '1;
    endcase
  end

  assign lane_pos = lane_mask << shift;
  assign merged   = (old_word & ~lane_pos) | ((new_val & lane_mask) << shift);
  assign extract  = (old_word >> shift) & lane_mask;

endmodule

// File: rtl/sdreg_lane_adapter.sv
module sdreg_lane_adapter
  import sdreg_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [31:0]       rsp_rdata,
  output logic              mem_en,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);

  localparam logic [ADDR_W-1:0] W_BLK  = ADDR_W'(OFS_BLKSZ);
  localparam logic [ADDR_W-1:0] W_HCTL = ADDR_W'(OFS_HCTL);

  adp_state_e        state_q;
  logic [ADDR_W-1:0] waddr_q;
  logic [1:0]        size_q;
  logic [4:0]        shift_q;
  logic [31:0]       wval_q;
  logic [31:0]       wbuf_q;
  logic [31:0]       rdata_q;
  logic              rmw_q;
  logic [15:0]       shadow_q;

  logic [ADDR_W-1:0] sw_word;
  logic [4:0]        sw_shift;
  logic [31:0]       sw_clr;
  logic              sw_xfer, sw_cmd;
  logic [31:0]       ln_merged, ln_extract;
  logic              accept;

  sdreg_addr_swz #(.ADDR_W(ADDR_W)) u_swz (
    .is_write  (req_write),
    .size      (req_size),
    .addr      (req_addr),
    .word_addr (sw_word),
    .lane_shift(sw_shift),
    .clr_mask  (sw_clr),
    .hit_xfer  (sw_xfer),
    .hit_cmd   (sw_cmd)
  );

  sdreg_lane_unit #(.DATA_W(32)) u_lane (
    .size    (size_q),
    .shift   (shift_q),
    .old_word(mem_rdata),
    .new_val (wval_q),
    .merged  (ln_merged),
    .extract (ln_extract)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rsp_valid = (state_q == ST_RESP);
  assign rsp_rdata = rdata_q;
  assign mem_en    = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we    = (state_q == ST_WRITE);
  assign mem_addr  = waddr_q;
  assign mem_wdata = wbuf_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      waddr_q  <= '0;
      size_q   <= SZ_WORD;
      shift_q  <= '0;
      wval_q   <= '0;
      wbuf_q   <= '0;
      rdata_q  <= '0;
      rmw_q    <= 1'b0;
      shadow_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          waddr_q <= sw_word;
          size_q  <= req_size;
          shift_q <= sw_shift;
          wval_q  <= req_wdata & ~sw_clr;
          rdata_q <= '0;
          rmw_q   <= 1'b0;
          if (!req_write) begin
            state_q <= ST_READ;
          end else if (req_size != SZ_BYTE && req_size != SZ_HALF) begin
            wbuf_q  <= req_wdata;
            state_q <= ST_WRITE;
          end else if (sw_xfer) begin
            shadow_q <= req_wdata[15:0];
            state_q  <= ST_RESP;
          end else if (sw_cmd) begin
            wbuf_q  <= {req_wdata[15:0], shadow_q};
            state_q <= ST_WRITE;
          end else begin
            rmw_q   <= 1'b1;
            state_q <= ST_READ;
          end
        end
        ST_READ:  state_q <= ST_MERGE;
        ST_MERGE: begin
          if (rmw_q) begin
            wbuf_q  <= ln_merged;
            state_q <= ST_WRITE;
          end else begin
            rdata_q <= ln_extract;
            state_q <= ST_RESP;
          end
        end
        ST_WRITE: state_q <= ST_RESP;
        ST_RESP:  if (rsp_ready) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R10

  AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> mem_addr[1:0] == 2'b00); // R1

  AST_RMW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we && rmw_q |-> $past(mem_en && !mem_we, 2) && $past(mem_addr, 2) == mem_addr); // R6

  AST_ONE_INFLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R9

  AST_HCTL_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we && rmw_q && mem_addr == W_HCTL && size_q == SZ_BYTE && shift_q == 5'd0
    |-> mem_wdata[0] == 1'b0 && mem_wdata[2] == 1'b0); // R8

  AST_BLK_DMA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en && mem_we && rmw_q && mem_addr == W_BLK && size_q == SZ_HALF && shift_q == 5'd0
    |-> mem_wdata[14:12] == 3'b000); // R7

endmodule

// File: tb/sim_sdreg_lane_adapter.sv
module sim_sdreg_lane_adapter;

  localparam int unsigned AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0;
  logic [1:0]    req_size = 2'd2;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          req_ready, rsp_valid, mem_en, mem_we;
  logic [31:0]   rsp_rdata, mem_wdata;
  logic [31:0]   mem_rdata = '0;
  logic [AW-1:0] mem_addr;

  logic [31:0]   regs [0:63];
  int            n_wr = 0, n_rd = 0;
  int            checks = 0, fails = 0;

  always #5 clk = ~clk;

  sdreg_lane_adapter #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // Register file model: big-endian words, one-cycle read latency.
  always @(posedge clk) begin
    if (mem_en && mem_we) begin
      regs[mem_addr[AW-1:2]] <= mem_wdata;
      n_wr <= n_wr + 1;
    end else if (mem_en) begin
      mem_rdata <= regs[mem_addr[AW-1:2]];
      n_rd <= n_rd + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [AW-1:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    while (!rsp_valid) @(negedge clk);
    rd = rsp_rdata;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  task automatic t_reset;
    check("R9 reset req_ready", {31'b0, req_ready}, 32'h1);
    check("R10 reset rsp_valid", {31'b0, rsp_valid}, 32'h0);
    check("R1 reset mem_en", {31'b0, mem_en}, 32'h0);
  endtask

  task automatic t_word;
    logic [31:0] r;
    access(1'b1, 2'd2, 8'h20, 32'hCAFE_F00D, r);
    check("R1 word write stored", regs[8], 32'hCAFE_F00D);
    check("R10 write response data", r, 32'h0);
    access(1'b0, 2'd2, 8'h23, 32'h0, r);
    check("R1 word read low bits ignored", r, 32'hCAFE_F00D);
  endtask

  task automatic t_half_read;
    logic [31:0] r;
    regs[5] = 32'hDEAD_BEEF;
    access(1'b0, 2'd1, 8'h14, 32'h0, r);
    check("R2 half read 0x14", r, 32'h0000_BEEF);
    access(1'b0, 2'd1, 8'h16, 32'h0, r);
    check("R2 half read 0x16", r, 32'h0000_DEAD);
    regs[63] = 32'h1111_2222;
    access(1'b0, 2'd1, 8'hFE, 32'h0, r);
    check("R2 host version 0xFE", r, 32'h0000_2222);
    access(1'b0, 2'd1, 8'hFC, 32'h0, r);
    check("R2 neighbour 0xFC", r, 32'h0000_2222);
  endtask

  task automatic t_byte_read;
    logic [31:0] r;
    logic [31:0] w;
    w = 32'hDEAD_BEEF;
    regs[5] = w;
    for (int i = 0; i < 4; i++) begin
      access(1'b0, 2'd0, AW'(8'h14 + i), 32'h0, r);
      check($sformatf("R3 byte read lane %0d", i), r, (w >> (8 * i)) & 32'hFF);
    end
  endtask

  task automatic t_cmd_merge;
    logic [31:0] r;
    int wr0, rd0;
    regs[3] = 32'h5555_5555;
    wr0 = n_wr; rd0 = n_rd;
    access(1'b1, 2'd1, 8'h0C, 32'h0000_1234, r);
    check("R4 no downstream write", n_wr - wr0, 0);
    check("R4 no downstream read", n_rd - rd0, 0);
    check("R4 word untouched", regs[3], 32'h5555_5555);
    access(1'b1, 2'd1, 8'h0E, 32'h0000_ABCD, r);
    check("R5 merged word", regs[3], 32'hABCD_1234);
    check("R5 one write", n_wr - wr0, 1);
    check("R5 no read", n_rd - rd0, 0);
  endtask

  task automatic t_rmw;
    logic [31:0] r;
    int rd0;
    regs[6] = 32'h1122_3344;
    rd0 = n_rd;
    access(1'b1, 2'd1, 8'h1A, 32'h0000_A5A5, r);
    check("R6 half lane upper", regs[6], 32'hA5A5_3344);
    check("R6 one read", n_rd - rd0, 1);
    access(1'b1, 2'd0, 8'h19, 32'h0000_0077, r);
    check("R6 byte lane 1", regs[6], 32'hA5A5_7744);
  endtask

  task automatic t_masks;
    logic [31:0] r;
    regs[1] = 32'hAAAA_5555;
    access(1'b1, 2'd1, 8'h04, 32'h0000_FFFF, r);
    check("R7 block size bits 14:12", regs[1], 32'hAAAA_8FFF);
    access(1'b1, 2'd1, 8'h06, 32'h0000_FFFF, r);
    check("R7 neighbour unmasked", regs[1], 32'hFFFF_8FFF);
    regs[10] = 32'h1122_3344;
    access(1'b1, 2'd0, 8'h28, 32'h0000_00FF, r);
    check("R8 host control bits 0,2", regs[10], 32'h1122_33FA);
    access(1'b1, 2'd0, 8'h29, 32'h0000_00FF, r);
    check("R8 neighbour unmasked", regs[10], 32'h1122_FFFA);
  endtask

  task automatic t_backpressure;
    logic [31:0] first;
    regs[12] = 32'h0BAD_F00D;
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_size = 2'd2; req_addr = 8'h30;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    check("R9 busy after accept", {31'b0, req_ready}, 32'h0);
    while (!rsp_valid) @(negedge clk);
    first = rsp_rdata;
    check("R10 stalled data", first, 32'h0BAD_F00D);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R10 held valid", {31'b0, rsp_valid}, 32'h1);
      check("R10 held data", rsp_rdata, first);
      check("R9 no new accept", {31'b0, req_ready}, 32'h0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R9 ready after response", {31'b0, req_ready}, 32'h1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) regs[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_word();
    t_half_read();
    t_byte_read();
    t_cmd_merge();
    t_rmw();
    t_masks();
    t_backpressure();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule